// File: doc/BRIEF.md
# Flash Write Enable and Block Protection Unit

This block holds the status byte of a serial flash and decides, one command at a time, whether a decoded command may run. It keeps four pieces of state: a busy flag for the running internal cycle, a write enable latch, a two-bit block protect field and a status lock bit. Program, sector erase, bulk erase and status write commands are checked against several conditions before they run. The latch must already be set. The target address must lie outside the range the protect field guards. The status lock bit and the external write-protect pin together form a hardware lock on status writes.

Commands arrive on a valid/ready port. The unit never applies back-pressure: `cmd_ready` is held high, so a command is consumed in any cycle where `cmd_valid` is high. Exactly one cycle later, the unit raises `dec_valid` for one cycle. In that cycle `dec_exec` tells whether the command ran (1) or was refused (0). A command that is refused changes no state. The array itself is not modelled. An accepted modifying command starts an internal counter that keeps the busy flag set for `BUSY_CYCLES` cycles. When the counter ends, the busy flag clears and so does the write enable latch. The status byte is visible on `status` at all times, including while a cycle is running.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset `status` is 8'h00 and `dec_valid` is 0. The status byte layout is: bit 0 busy, bit 1 write enable latch, bits 3:2 protect field, bit 7 status lock, and bits 6:4 always 0.
- R2: The command codes on `cmd_op` are 0 no-op, 1 enable writes, 2 disable writes, 3 status write, 4 page program, 5 sector erase, 6 bulk erase, 7 data read. When the unit is idle, enable writes sets the latch and disable writes clears it. Both are executed.
- R3: Status write, page program, sector erase and bulk erase are refused when the write enable latch is 0.
- R4: An accepted modifying command sets the busy bit starting with the decision cycle. The bit stays set for exactly `BUSY_CYCLES` cycles. It then clears, and the write enable latch clears in the same cycle.
- R5: While the busy bit is 1, every command, data read included, is refused and leaves `status` unchanged.
- R6: The protected sectors are given by bits 3:2 as follows: 00 protects none, 01 protects the top sector, 10 protects the top two sectors, and 11 protects all four. Sectors are 32 KB, selected by address bits 16:15. A page program or sector erase into a protected sector is refused.
- R7: Bulk erase runs only when the protect field is 00.
- R8: A status write is refused when bit 7 is 1 and `wp_n` is 0. In all other cases it loads bits 7 and 3:2 from `cmd_sr` in the decision cycle.
- R9: A refused modifying command leaves the write enable latch as it was and does not set the busy bit.
- R10: Every consumed command produces exactly one `dec_valid` pulse, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1; no back-pressure |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Byte address for program and erase |
| cmd_sr | input | 8 | New status value for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| dec_valid | output | 1 | Decision pulse for the previous command |
| dec_exec | output | 1 | 1 = executed, 0 = refused |
| status | output | 8 | Readable status byte |

## Verification
The hardest state to reach from the ports is a refusal caused by the hardware lock. To get there, the bench must first use a status write to set the lock bit. That write needs the latch set and needs the pin high. It then has to let the busy period finish, set the latch again, and only then present a status write with `wp_n` low. The bench also steps the protect field through 01, 10 and 11. For each setting it aims program and erase commands at the sector just inside the protected range and the sector just outside it. It also checks that refusals keep the latch set.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WEN    = 3'd1,
    OP_WDIS   = 3'd2,
    OP_SRW    = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_READ   = 3'd7
  } op_e;

  localparam int BP_W = 2;
endpackage

// File: rtl/wbp_busy_timer.sv
module wbp_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wbp_sector_guard.sv
module wbp_sector_guard #(
  parameter int SECT_W = 2
) (
  input  logic [wbp_pkg::BP_W-1:0] bp,
  input  logic [SECT_W-1:0]        sect,
  output logic                     sect_locked,
  output logic                     any_locked
);
  localparam int NUM_SECT = 1 << SECT_W;

  logic [NUM_SECT-1:0] lock_vec;

  // bp 0: none; bp all-ones: all; otherwise the top 2^(bp-1) sectors.
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    always_comb begin
      if (bp == '0)
        lock_vec[s] = 1'b0;
      else if (bp == '1)
        lock_vec[s] = 1'b1;
      else
        lock_vec[s] = (s >= (NUM_SECT - (1 << (int'(bp) - 1))));
    end
  end

  assign sect_locked = lock_vec[sect];
  assign any_locked  = |lock_vec;
endmodule

// File: rtl/wbp_status_reg.sv
module wbp_status_reg (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_wel,
  input  logic                     clr_wel,
  input  logic                     load,
  input  logic [7:0]               sr_in,
  output logic                     wel,
  output logic [wbp_pkg::BP_W-1:0] bp,
  output logic                     srwd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      bp   <= '0;
      srwd <= 1'b0;
    end else begin
      if (set_wel)
        wel <= 1'b1;
      else if (clr_wel)
        wel <= 1'b0;
      if (load) begin
        bp   <= sr_in[3:2];
        srwd <= sr_in[7];
      end
    end
  end
endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit #(
  parameter int ADDR_W      = 17,
  parameter int SECT_W      = 2,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_sr,
  input  logic              wp_n,
  output logic              dec_valid,
  output logic              dec_exec,
  output logic [7:0]        status
);
  import wbp_pkg::*;

  op_e              op;
  logic             busy, done;
  logic             wel, srwd;
  logic [BP_W-1:0]  bp;
  logic [SECT_W-1:0] sect;
  logic             sect_locked, any_locked;
  logic             hw_lock;
  logic             accept, start, set_wel, clr_cmd, load;
  logic             unused_bits;

  assign cmd_ready   = 1'b1;
  assign op          = op_e'(cmd_op);
  assign sect        = cmd_addr[ADDR_W-1 -: SECT_W];
  assign hw_lock     = srwd & ~wp_n;
  assign unused_bits = ^{cmd_addr[ADDR_W-SECT_W-1:0], cmd_sr[6:4], cmd_sr[1:0]};

  wbp_sector_guard #(.SECT_W(SECT_W)) guard_i (
    .bp          (bp),
    .sect        (sect),
    .sect_locked (sect_locked),
    .any_locked  (any_locked)
  );

  always_comb begin
    accept  = 1'b0;
    start   = 1'b0;
    set_wel = 1'b0;
    clr_cmd = 1'b0;
    load    = 1'b0;
    if (cmd_valid && !busy) begin
      unique case (op)
        OP_NOP, OP_READ: accept = 1'b1;
        OP_WEN: begin
          accept  = 1'b1;
          set_wel = 1'b1;
        end
        OP_WDIS: begin
          accept  = 1'b1;
          clr_cmd = 1'b1;
        end
        OP_SRW: begin
          accept = wel && !hw_lock;
          load   = accept;
        end
        OP_PROG, OP_SERASE: accept = wel && !sect_locked;
        OP_BERASE:          accept = wel && !any_locked;
        default:            accept = 1'b0;
      endcase
      start = accept && (op inside {OP_SRW, OP_PROG, OP_SERASE, OP_BERASE});
    end
  end

  wbp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  wbp_status_reg sreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_wel (set_wel),
    .clr_wel (clr_cmd | done),
    .load    (load),
    .sr_in   (cmd_sr),
    .wel     (wel),
    .bp      (bp),
    .srwd    (srwd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_exec  <= 1'b0;
    end else begin
      dec_valid <= cmd_valid;
      dec_exec  <= cmd_valid && accept;
    end
  end

  assign status = {srwd, 3'b000, bp, wel, busy};
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
  parameter int BUSY_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wp_n,
  input logic       dec_valid,
  input logic       dec_exec,
  input logic [7:0] status
);
  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n || !status[0]) run <= 0;
    else                      run <= run + 1;
  end

  a_r10_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> dec_valid);

  a_r2_wen_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[0] && cmd_op == 3'd1) |=> (status[1] && dec_exec));

  a_r5_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status[0]) |=> (dec_valid && !dec_exec));

  a_r3_no_latch_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[1] && cmd_op inside {3'd3, 3'd4, 3'd5, 3'd6}) |=> !dec_exec);

  a_r7_bulk_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6 && status[3:2] != 2'b00) |=> !dec_exec);

  a_r8_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && status[7] && !wp_n) |=> !dec_exec);

  a_r6_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4 && status[3:2] == 2'b11) |=> !dec_exec);

  a_r4_end_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (run < BUSY_CYCLES));

  a_r9_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[0] && cmd_op inside {3'd3, 3'd4, 3'd5, 3'd6}) |=>
      (dec_exec == status[0]));

  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);
endmodule

bind flash_wp_unit wbp_checker #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wp_n      (wp_n),
  .dec_valid (dec_valid),
  .dec_exec  (dec_exec),
  .status    (status)
);

// File: tb/flash_wp_unit_tb_top.sv
module flash_wp_unit_tb_top;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [16:0] cmd_addr = '0;
  logic [7:0]  cmd_sr = '0;
  logic        wp_n = 1'b1;
  logic        dec_valid, dec_exec;
  logic [7:0]  status;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_wp_unit #(.ADDR_W(17), .SECT_W(2), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_sr(cmd_sr), .wp_n(wp_n),
    .dec_valid(dec_valid), .dec_exec(dec_exec), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [16:0] a, input logic [7:0] sr,
                      input logic wp, input logic exp_exec, input logic [7:0] exp_st,
                      input string tag);
    cmd_op = op; cmd_addr = a; cmd_sr = sr; wp_n = wp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R10 dec_valid"}, dec_valid, 1'b1);
    chk({tag, " exec"}, dec_exec, exp_exec);
    chk({tag, " status"}, status, exp_st);
  endtask

  task automatic wait_idle(input logic [7:0] exp_st, input string tag);
    for (int i = 0; i < 100 && status[0]; i++) @(negedge clk);
    chk({tag, " R4 after cycle"}, status, exp_st);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 8'h00);
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 cmd_ready", cmd_ready, 1'b1);
  endtask

  task automatic t_latch;
    send(3'd1, 0, 0, 1, 1, 8'h02, "R2 wen");
    send(3'd2, 0, 0, 1, 1, 8'h00, "R2 wdis");
    @(negedge clk);
    chk("R10 no cmd no pulse", dec_valid, 1'b0);
  endtask

  task automatic t_no_latch;
    send(3'd4, 17'h00000, 0, 1, 0, 8'h00, "R3 prog no latch");
    send(3'd3, 0, 8'h84, 1, 0, 8'h00, "R3 srw no latch");
  endtask

  task automatic t_busy_len;
    send(3'd1, 0, 0, 1, 1, 8'h02, "R2 wen");
    send(3'd4, 17'h00000, 0, 1, 1, 8'h03, "R4 prog start");
    repeat (BUSY - 1) @(negedge clk);
    chk("R4 last busy cycle", status, 8'h03);
    @(negedge clk);
    chk("R4 busy ended latch clear", status, 8'h00);
  endtask

  task automatic t_busy_refuse;
    send(3'd1, 0, 0, 1, 1, 8'h02, "R2 wen");
    send(3'd5, 17'h08000, 0, 1, 1, 8'h03, "R4 erase start");
    send(3'd7, 0, 0, 1, 0, 8'h03, "R5 read busy");
    send(3'd2, 0, 0, 1, 0, 8'h03, "R5 wdis busy");
    send(3'd3, 0, 8'h8C, 1, 0, 8'h03, "R5 srw busy");
    wait_idle(8'h00, "R5");
  endtask

  task automatic t_protect_top;
    send(3'd1, 0, 0, 1, 1, 8'h02, "R2 wen");
    send(3'd3, 0, 8'h84, 1, 1, 8'h87, "R8 srw soft mode");
    wait_idle(8'h84, "R8");
    send(3'd1, 0, 0, 1, 1, 8'h86, "R2 wen");
    send(3'd4, 17'h18000, 0, 1, 0, 8'h86, "R6 R9 prog top locked");
    send(3'd6, 0, 0, 1, 0, 8'h86, "R7 bulk refused bp01");
    send(3'd3, 0, 8'h08, 0, 0, 8'h86, "R8 hw lock refuse");
    send(3'd5, 17'h10000, 0, 1, 1, 8'h87, "R6 erase sector2 open");
    wait_idle(8'h84, "R6");
  endtask

  task automatic t_protect_more;
    send(3'd1, 0, 0, 1, 1, 8'h86, "R2 wen");
    send(3'd3, 0, 8'h08, 1, 1, 8'h0B, "R8 srw pin high");
    wait_idle(8'h08, "R8");
    send(3'd1, 0, 0, 1, 1, 8'h0A, "R2 wen");
    send(3'd5, 17'h10000, 0, 1, 0, 8'h0A, "R6 erase sector2 locked");
    send(3'd4, 17'h0FFFF, 0, 1, 1, 8'h0B, "R6 prog sector1 open");
    wait_idle(8'h08, "R6");
    send(3'd1, 0, 0, 1, 1, 8'h0A, "R2 wen");
    send(3'd3, 0, 8'h0C, 1, 1, 8'h0F, "R8 srw bp11");
    wait_idle(8'h0C, "R8");
    send(3'd1, 0, 0, 1, 1, 8'h0E, "R2 wen");
    send(3'd4, 17'h00000, 0, 1, 0, 8'h0E, "R6 prog all locked");
    send(3'd3, 0, 8'h00, 0, 1, 8'h03, "R8 srw pin low unlocked");
    wait_idle(8'h00, "R8");
    send(3'd1, 0, 0, 1, 1, 8'h02, "R2 wen");
    send(3'd6, 0, 0, 1, 1, 8'h03, "R7 bulk open");
    wait_idle(8'h00, "R7");
    send(3'd7, 0, 0, 1, 1, 8'h00, "R2 read idle");
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_busy_len();
    t_busy_refuse();
    t_protect_top();
    t_protect_more();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule